// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether a frame should be kept, based on its 48-bit destination address. The six address bytes arrive one per accepted beat on a byte stream. A start strobe marks the first byte. While the bytes go past, a bit-serial CRC-32 is folded over them. Six of the resulting bits address one bit of a 64-bit group hash table. That table is held as two 32-bit words, which software loads through a simple write port.

Once the sixth byte has been taken, the filter emits a one-cycle decision pulse. The pulse carries an accept flag and the 6-bit table bucket that was consulted. The decision follows these rules:
- Group addresses are judged by the hash table.
- Individual (unicast) addresses must equal the programmed station address.
- The all-ones broadcast address can be dropped by a reject control.
- An all-groups control makes every group address hit.
- Promiscuous mode keeps everything.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, match_valid, match_accept and match_bucket are 0, and both table words are cleared. A group address is therefore rejected until the table is written.
- R2: The CRC register starts at 32'hFFFF_FFFF. Bytes are folded in the order they arrive, and each byte is taken least significant bit first. For each bit the register shifts left by one, and 32'h04C1_1DB7 is XORed in when the bit leaving bit 31, XOR the data bit, is 1. The result is not inverted.
- R3: match_bucket[5] equals CRC bit 0, where 1 means the high table word. match_bucket[4:0] is CRC bits 5:1 in reversed order: bucket bit 4 is CRC bit 1 and bucket bit 0 is CRC bit 5.
- R4: A non-broadcast address whose first byte has bit 0 set is accepted exactly when the table bit at match_bucket is set. The word is chosen by match_bucket[5] and the bit by match_bucket[4:0].
- R5: A table write with tbl_wr_high=1 replaces the whole high word and with tbl_wr_high=0 the whole low word. The new contents govern every decision that follows.
- R6: With all_groups=1, every non-broadcast group address is accepted whatever the table holds.
- R7: With promisc_en=1, every address is accepted, including broadcast while bcast_reject=1.
- R8: The all-ones address is accepted when bcast_reject=0 and rejected when bcast_reject=1. The table is not consulted.
- R9: An address whose first byte has bit 0 clear is accepted only when all 48 bits equal station_addr. The first received byte is compared with station_addr[47:40].
- R10: match_valid is high for exactly one cycle. It rises on the clock edge after the edge that takes the sixth byte.
- R11: A beat with rx_valid and rx_start restarts the CRC and the byte count, even in the middle of an address. Bytes that arrive before any start, or after the sixth byte, produce no decision.
- R12: Cycles with rx_valid low consume nothing. Idle gaps between address bytes do not change the decision or the bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Address byte present this cycle |
| rx_start | input | 1 | This byte is the first address byte |
| rx_byte | input | 8 | Address byte |
| tbl_wr_en | input | 1 | Write one hash table word |
| tbl_wr_high | input | 1 | 1 selects the high word, 0 the low word |
| tbl_wr_data | input | 32 | New word contents |
| station_addr | input | 48 | Own unicast address, first byte in bits 47:40 |
| promisc_en | input | 1 | Accept every frame |
| bcast_reject | input | 1 | Drop the all-ones address |
| all_groups | input | 1 | Every group address hits |
| match_valid | output | 1 | One-cycle decision strobe |
| match_accept | output | 1 | Keep the frame |
| match_bucket | output | 6 | Table word select and bit position used |

## Verification
The hardest outcomes to reach from the ports are hits and misses on a chosen table bit. The bucket comes from a CRC that cannot be steered by hand. The bench therefore runs its own bitwise model of the CRC and the index mapping for each address. It then loads the table either with random words or with a single bit placed at the predicted bucket, moving that bit to the opposite word to force a miss. Restart in mid-address and stalled byte streams are produced by breaking a frame off with a new start, and by spreading bytes across idle cycles.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int CRC_W = 32;

  // Fold one byte into the running CRC, least significant data bit first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(
    input logic [CRC_W-1:0] c_in,
    input logic [7:0]       d,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int j = 0; j < 8; j++) begin
      fb = c[CRC_W-1] ^ d[j];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/mhf_addr_capture.sv
module mhf_addr_capture #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [7:0]        in_byte,
  output logic              take,
  output logic              take_first,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             active_q;

  assign take       = in_valid && (in_start || active_q);
  assign take_first = in_valid && in_start;

  always_comb begin
    if (in_start) cnt_next = CNT_W'(1);
    else          cnt_next = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      addr_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        cnt_q    <= cnt_next;
        addr_q   <= {addr_q[ADDR_W-9:0], in_byte};
        active_q <= (cnt_next < CNT_W'(ADDR_BYTES));
        done_q   <= (cnt_next == CNT_W'(ADDR_BYTES));
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(ADDR_BYTES)); // R11

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !active_q); // R11

endmodule

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY  = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] SEED  = 32'hFFFF_FFFF,
  parameter int               OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             take_first,
  input  logic [7:0]       in_byte,
  output logic [OUT_W-1:0] crc_low
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;

  assign crc_base = take_first ? SEED : crc_q;

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= SEED;
    else if (take) crc_q <= crc_fold_byte(crc_base, in_byte, POLY);
  end

  assign crc_low = crc_q[OUT_W-1:0];

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int WORD_W = 32,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic [POS_W-1:0]  rd_pos,
  output logic              rd_hit
);

  logic [WORD_W-1:0] mem [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem[0] <= '0;
      mem[1] <= '0;
    end else if (wr_en) begin
      mem[wr_sel] <= wr_data;
    end
  end

  assign rd_hit = mem[rd_sel][rd_pos];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst)) |-> (mem[$past(wr_sel)] == $past(wr_data))); // R5

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          ADDR_BYTES   = 6,
  parameter int          TABLE_WORD_W = 32,
  parameter logic [31:0] CRC_POLY     = 32'h04C1_1DB7,
  parameter logic [31:0] CRC_SEED     = 32'hFFFF_FFFF,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int POS_W  = $clog2(TABLE_WORD_W),
  localparam int BKT_W  = POS_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_valid,
  input  logic                    rx_start,
  input  logic [7:0]              rx_byte,
  input  logic                    tbl_wr_en,
  input  logic                    tbl_wr_high,
  input  logic [TABLE_WORD_W-1:0] tbl_wr_data,
  input  logic [ADDR_W-1:0]       station_addr,
  input  logic                    promisc_en,
  input  logic                    bcast_reject,
  input  logic                    all_groups,
  output logic                    match_valid,
  output logic                    match_accept,
  output logic [BKT_W-1:0]        match_bucket
);

  logic              take;
  logic              take_first;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [BKT_W-1:0]  crc_low;
  logic [POS_W-1:0]  bit_pos;
  logic              word_sel;
  logic              tbl_hit;
  logic              is_bcast;
  logic              is_group;
  logic              accept_next;

  mhf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (rx_valid),
    .in_start   (rx_start),
    .in_byte    (rx_byte),
    .take       (take),
    .take_first (take_first),
    .addr_q     (addr_q),
    .done_q     (done_q)
  );

  mhf_crc_engine #(.POLY(CRC_POLY), .SEED(CRC_SEED), .OUT_W(BKT_W)) u_crc (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .take_first (take_first),
    .in_byte    (rx_byte),
    .crc_low    (crc_low)
  );

  // Bucket: CRC bit 0 picks the word, CRC bits POS_W:1 reversed pick the bit.
  assign word_sel = crc_low[0];
  for (genvar g = 0; g < POS_W; g++) begin : g_rev
    assign bit_pos[g] = crc_low[POS_W - g];
  end

  mhf_hash_table #(.WORD_W(TABLE_WORD_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_wr_en),
    .wr_sel  (tbl_wr_high),
    .wr_data (tbl_wr_data),
    .rd_sel  (word_sel),
    .rd_pos  (bit_pos),
    .rd_hit  (tbl_hit)
  );

  assign is_bcast = &addr_q;
  assign is_group = addr_q[ADDR_W-8];

  always_comb begin
    if (promisc_en)    accept_next = 1'b1;
    else if (is_bcast) accept_next = !bcast_reject;
    else if (is_group) accept_next = all_groups || tbl_hit;
    else               accept_next = (addr_q == station_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid  <= 1'b0;
      match_accept <= 1'b0;
      match_bucket <= '0;
    end else begin
      match_valid <= done_q;
      if (done_q) begin
        match_accept <= accept_next;
        match_bucket <= {word_sel, bit_pos};
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    match_valid |=> !match_valid); // R10

  AST_DECIDE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done_q |=> match_valid); // R10

  AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (match_valid && $past(promisc_en)) |-> match_accept); // R7

  AST_BCAST_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (match_valid && $past(is_bcast && bcast_reject && !promisc_en)) |-> !match_accept); // R8

endmodule

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid, rx_start;
  logic [7:0]  rx_byte;
  logic        tbl_wr_en, tbl_wr_high;
  logic [31:0] tbl_wr_data;
  logic [47:0] station_addr;
  logic        promisc_en, bcast_reject, all_groups;
  logic        match_valid, match_accept;
  logic [5:0]  match_bucket;

  int checks = 0;
  int errors = 0;
  logic [31:0] ref_hi, ref_lo;
  logic        got_v, got_a, seen_early, after_v;
  logic [5:0]  got_b;

  always #10 clk = ~clk;

  mcast_hash_filter i_mcast_hash_filter (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_start(rx_start), .rx_byte(rx_byte),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_high(tbl_wr_high), .tbl_wr_data(tbl_wr_data),
    .station_addr(station_addr), .promisc_en(promisc_en), .bcast_reject(bcast_reject),
    .all_groups(all_groups), .match_valid(match_valid), .match_accept(match_accept),
    .match_bucket(match_bucket)
  );

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;

  // {address, promisc, bcast_reject, all_groups, expect: 0 reject, 1 accept, 2 model}
  localparam int NV = 10;
  localparam logic [52:0] VECS [NV] = '{
    {48'h02_11_22_33_44_55, 3'b000, 2'd1},
    {48'h02_11_22_33_44_56, 3'b000, 2'd0},
    {48'hFF_FF_FF_FF_FF_FF, 3'b000, 2'd1},
    {48'hFF_FF_FF_FF_FF_FF, 3'b010, 2'd0},
    {48'hFF_FF_FF_FF_FF_FF, 3'b110, 2'd1},
    {48'h0A_BB_CC_DD_EE_FF, 3'b100, 2'd1},
    {48'h01_00_5E_00_00_01, 3'b001, 2'd1},
    {48'h01_00_5E_00_00_01, 3'b000, 2'd2},
    {48'h33_33_00_00_00_01, 3'b010, 2'd2},
    {48'h01_80_C2_00_00_0E, 3'b000, 2'd2}
  };

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic        m;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = a[47 - 8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        m = c[31];
        c = {c[30:0], 1'b0};
        if (m ^ b[j]) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_bucket(input logic [47:0] a);
    logic [31:0] c;
    c = ref_crc(a);
    return {c[0], c[1], c[2], c[3], c[4], c[5]};
  endfunction

  function automatic logic ref_accept(input logic [47:0] a, input logic p,
                                      input logic br, input logic ag);
    logic [5:0] k;
    k = ref_bucket(a);
    if (p) return 1'b1;
    if (&a) return !br;
    if (a[40]) return ag || (k[5] ? ref_hi[k[4:0]] : ref_lo[k[4:0]]);
    return a == station_addr;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic hi, input logic [31:0] d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_high = hi; tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    if (hi) ref_hi = d; else ref_lo = d;
  endtask

  task automatic send_frame(input logic [47:0] a, input int gap);
    seen_early = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          seen_early |= match_valid;
          rx_valid = 1'b0; rx_start = 1'b0; rx_byte = 8'hA5;
        end
      end
      @(negedge clk);
      seen_early |= match_valid;
      rx_valid = 1'b1; rx_start = (i == 0); rx_byte = a[47 - 8*i -: 8];
    end
    @(negedge clk);
    seen_early |= match_valid;
    rx_valid = 1'b0; rx_start = 1'b0;
    @(negedge clk);
    got_v = match_valid; got_a = match_accept; got_b = match_bucket;
    @(negedge clk);
    after_v = match_valid;
  endtask

  task automatic frame_check(input string tag, input logic [47:0] a, input int gap);
    send_frame(a, gap);
    check({tag, " R10 early"}, seen_early, 0);
    check({tag, " R10 pulse"}, got_v, 1);
    check({tag, " R10 single"}, after_v, 0);
    check({tag, " R3 bucket"}, got_b, ref_bucket(a));
    check({tag, " R4 accept"}, got_a, ref_accept(a, promisc_en, bcast_reject, all_groups));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  k;
    logic        any_v;
    rst = 1'b1; rx_valid = 0; rx_start = 0; rx_byte = 0;
    tbl_wr_en = 0; tbl_wr_high = 0; tbl_wr_data = 0;
    station_addr = STATION; promisc_en = 0; bcast_reject = 0; all_groups = 0;
    ref_hi = 0; ref_lo = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", match_valid, 0);
    check("R1 accept after reset", match_accept, 0);
    check("R1 bucket after reset", match_bucket, 0);

    // R1: cleared table rejects a group address.
    send_frame(48'h01_00_5E_7F_00_09, 0);
    check("R1 empty table reject", got_a, 0);
    check("R1 empty table pulse", got_v, 1);

    // Vector table walk (R2 R3 R4 R6 R7 R8 R9).
    write_word(1'b1, 32'hA5A5_0F0F);
    write_word(1'b0, 32'h1234_5678);
    for (int v = 0; v < NV; v++) begin
      a = VECS[v][52:5];
      promisc_en = VECS[v][4]; bcast_reject = VECS[v][3]; all_groups = VECS[v][2];
      send_frame(a, v % 2);
      check("R10 vec pulse", got_v, 1);
      check("R2 R3 vec bucket", got_b, ref_bucket(a));
      if (VECS[v][1:0] == 2'd2)
        check("R4 vec accept", got_a, ref_accept(a, promisc_en, bcast_reject, all_groups));
      else
        check("R6 R7 R8 R9 vec accept", got_a, VECS[v][0]);
    end
    promisc_en = 0; bcast_reject = 0; all_groups = 0;

    // Random tables and group addresses against the model (R2 R3 R4 R5).
    for (int n = 0; n < 40; n++) begin
      if (n % 5 == 0) begin
        write_word(1'b1, $urandom);
        write_word(1'b0, $urandom);
      end
      a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      a[40] = 1'b1;
      if (&a) a[0] = 1'b0;
      frame_check("rand", a, n % 3);
    end

    // R5: a single bit placed at the predicted bucket, then moved to the other word.
    a = 48'h01_00_5E_12_34_56;
    k = ref_bucket(a);
    write_word(k[5], 32'h1 << k[4:0]);
    write_word(!k[5], 32'h0);
    send_frame(a, 0);
    check("R5 R4 single bit hit", got_a, 1);
    write_word(!k[5], 32'h1 << k[4:0]);
    write_word(k[5], ~(32'h1 << k[4:0]));
    send_frame(a, 0);
    check("R5 R4 wrong word miss", got_a, 0);
    all_groups = 1;
    send_frame(a, 0);
    check("R6 all groups hit", got_a, 1);
    all_groups = 0;

    // R11: restart in the middle of an address.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_start = (i == 0); rx_byte = 8'h5A + 8'(i);
    end
    frame_check("R11 restart", 48'h03_DE_AD_BE_EF_01, 0);

    // R11: bytes with no start are ignored.
    any_v = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      any_v |= match_valid;
      rx_valid = 1; rx_start = 0; rx_byte = 8'hFF;
    end
    @(negedge clk); any_v |= match_valid; rx_valid = 0;
    repeat (3) begin @(negedge clk); any_v |= match_valid; end
    check("R11 no start no decision", any_v, 0);

    // R12: long gaps give the same result as a packed stream.
    frame_check("R12 gaps", 48'h01_00_5E_00_00_FB, 4);
    frame_check("R12 packed", 48'h01_00_5E_00_00_FB, 0);

    // R9: unicast equal except for one bit in the first byte.
    send_frame(STATION ^ 48'h04_00_00_00_00_00, 0);
    check("R9 near miss reject", got_a, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule